// File: doc/BRIEF.md
# Thermal Trip and Clock Throttle Unit

This block watches an unsigned digital temperature word and acts on two programmable trip levels. Past the lower (hot) level it starts throttling: the downstream clock enable is held low for a programmable number of cycles at the start of every fixed 16-cycle window. Past the upper (critical) level it raises a shutdown request that stays high until reset. Software can also force throttling through a control bit. The hardware comparator works without software, so it serves as a fast fail-safe.

Hardware throttling has hysteresis. It engages as soon as the temperature reaches the hot level. It releases only when the temperature plus a programmable margin falls below that level. A new stall count, or a change between throttled and free-running, is applied only when a window starts, so the stall pattern inside a window never changes partway through. Two status outputs report separately whether the hardware comparator or the software bit is asking for throttling.

Top module: `thermal_throttle_unit`

## Requirements
- R1: While no throttle source is active, `clk_en_o` is high on every cycle, whatever the value of `duty_i`.
- R2: While throttling with stall setting N (0..15 on `duty_i`), `clk_en_o` is low for exactly window positions 0..N-1 of each 16-cycle window and high for positions N..15. N=0 never stalls. Position k is the window position in the k-th cycle after the first clock edge with reset low, counted modulo 16.
- R3: A temperature at or above `thr_crit_i` sets `shutdown_o` high at the next clock edge.
- R4: Once high, `shutdown_o` stays high regardless of temperature until synchronous reset.
- R5: A temperature at or above `thr_hot_i` sets `throt_hw_o` at the next clock edge, with `sw_throttle_i` low.
- R6: Once set, `throt_hw_o` stays high while `temp_i + hyst_i >= thr_hot_i`. It clears at the next edge once `temp_i + hyst_i < thr_hot_i`, using a sum that cannot overflow.
- R7: `throt_sw_o` follows `sw_throttle_i` one cycle later, and software throttling stalls the clock even at low temperature.
- R8: `throt_hw_o` and `throt_sw_o` are independent. Each reflects only its own source, and both may be high at once.
- R9: The stall count used in a window is latched only at the edge that starts window position 0. It comes from `duty_i` when either status flag is high, and is 0 otherwise. Changes inside a window leave that window's pattern unchanged.
- R10: After reset, `clk_en_o` is high and `throt_hw_o`, `throt_sw_o` and `shutdown_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_i | input | TEMP_W | Unsigned temperature reading |
| thr_hot_i | input | TEMP_W | Throttle trip level |
| thr_crit_i | input | TEMP_W | Shutdown trip level |
| hyst_i | input | TEMP_W | Hysteresis margin for hardware release |
| duty_i | input | DUTY_W | Stalled cycles per window |
| sw_throttle_i | input | 1 | Software throttle request |
| clk_en_o | output | 1 | Clock enable for the gated domain |
| throt_hw_o | output | 1 | Throttling requested by the comparator |
| throt_sw_o | output | 1 | Throttling requested by software |
| shutdown_o | output | 1 | Sticky shutdown request |

## Verification
Both status flags and the shutdown output pass through one register, so they are due one clock edge after the input changes. The bench drives inputs on a falling edge and samples them on the next falling edge. A change to the stall pattern appears only once the window counter wraps. The bench keeps its own cycle count from the release of reset to find window position 0. Before it counts stalled positions over a full window, it waits at least one full window after any stimulus. The boundary checks change inputs at a known mid-window position and expect the remaining positions of that window to keep the old pattern.

// File: rtl/thermal_throttle_pkg.sv
package thermal_throttle_pkg;

    localparam int TT_TEMP_W = 8;
    localparam int TT_DUTY_W = 4;

    typedef enum logic [0:0] {
        TT_FREE     = 1'b0,
        TT_STALLING = 1'b1
    } tt_mode_e;

    typedef struct packed {
        logic hw;
        logic sw;
    } tt_src_t;

    function automatic logic tt_any(input tt_src_t s);
        return s.hw | s.sw;
    endfunction

endpackage

// File: rtl/tt_trip_compare.sv
module tt_trip_compare #(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] thr_hot,
    input  logic [TEMP_W-1:0] thr_crit,
    input  logic [TEMP_W-1:0] hyst,
    output logic              hw_req_q,
    output logic              crit_hit
);
    localparam int SUM_W = TEMP_W + 1;

    logic [SUM_W-1:0] margin_sum;
    logic             at_hot;
    logic             cooled;

    always_comb begin
        margin_sum = {1'b0, temp} + {1'b0, hyst};
        at_hot     = temp >= thr_hot;
        cooled     = margin_sum < {1'b0, thr_hot};
        crit_hit   = temp >= thr_crit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_req_q <= 1'b0;
        end else if (at_hot) begin
            hw_req_q <= 1'b1;
        end else if (cooled) begin
            hw_req_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tt_shutdown_latch.sv
module tt_shutdown_latch (
    input  logic clk,
    input  logic rst,
    input  logic crit_hit,
    output logic shut_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shut_q <= 1'b0;
        end else if (crit_hit) begin
            shut_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tt_duty_gen.sv
module tt_duty_gen
    import thermal_throttle_pkg::*;
#(
    parameter int DUTY_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              throttle_any,
    input  logic [DUTY_W-1:0] duty_set,
    output logic              clk_en,
    output logic [DUTY_W-1:0] win_pos,
    output logic [DUTY_W-1:0] act_duty,
    output tt_mode_e          mode
);
    localparam logic [DUTY_W-1:0] LAST_POS = {DUTY_W{1'b1}};

    logic wrap;

    always_comb begin
        wrap   = win_pos == LAST_POS;
        clk_en = win_pos >= act_duty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_pos  <= '0;
            act_duty <= '0;
            mode     <= TT_FREE;
        end else begin
            win_pos <= win_pos + 1'b1;
            if (wrap) begin
                act_duty <= throttle_any ? duty_set : '0;
                mode     <= throttle_any ? TT_STALLING : TT_FREE;
            end
        end
    end
endmodule

// File: rtl/thermal_throttle_unit.sv
module thermal_throttle_unit
    import thermal_throttle_pkg::*;
#(
    parameter int TEMP_W = TT_TEMP_W,
    parameter int DUTY_W = TT_DUTY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] thr_hot_i,
    input  logic [TEMP_W-1:0] thr_crit_i,
    input  logic [TEMP_W-1:0] hyst_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              sw_throttle_i,
    output logic              clk_en_o,
    output logic              throt_hw_o,
    output logic              throt_sw_o,
    output logic              shutdown_o
);
    tt_src_t           src;
    logic              sw_q;
    logic              hw_q;
    logic              crit_hit;
    logic [DUTY_W-1:0] win_pos;
    logic [DUTY_W-1:0] act_duty;
    tt_mode_e          mode;

    always_ff @(posedge clk) begin
        if (rst) sw_q <= 1'b0;
        else     sw_q <= sw_throttle_i;
    end

    tt_trip_compare #(.TEMP_W(TEMP_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .temp     (temp_i),
        .thr_hot  (thr_hot_i),
        .thr_crit (thr_crit_i),
        .hyst     (hyst_i),
        .hw_req_q (hw_q),
        .crit_hit (crit_hit)
    );

    tt_shutdown_latch u_shut (
        .clk      (clk),
        .rst      (rst),
        .crit_hit (crit_hit),
        .shut_q   (shutdown_o)
    );

    always_comb begin
        src.hw = hw_q;
        src.sw = sw_q;
    end

    tt_duty_gen #(.DUTY_W(DUTY_W)) u_duty (
        .clk          (clk),
        .rst          (rst),
        .throttle_any (tt_any(src)),
        .duty_set     (duty_i),
        .clk_en       (clk_en_o),
        .win_pos      (win_pos),
        .act_duty     (act_duty),
        .mode         (mode)
    );

    assign throt_hw_o = src.hw;
    assign throt_sw_o = src.sw;
endmodule

// File: rtl/thermal_throttle_unit_chk.sv
module thermal_throttle_unit_chk #(
    parameter int TEMP_W = 8,
    parameter int DUTY_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [TEMP_W-1:0] temp_i,
    input logic [TEMP_W-1:0] thr_hot_i,
    input logic [TEMP_W-1:0] thr_crit_i,
    input logic [TEMP_W-1:0] hyst_i,
    input logic              sw_throttle_i,
    input logic              clk_en_o,
    input logic              throt_hw_o,
    input logic              throt_sw_o,
    input logic              shutdown_o,
    input logic [DUTY_W-1:0] win_pos,
    input logic [DUTY_W-1:0] act_duty
);
    a_r3_crit_sets_shutdown: assert property (@(posedge clk) disable iff (rst)
        (temp_i >= thr_crit_i) |=> shutdown_o);

    a_r4_shutdown_sticky: assert property (@(posedge clk) disable iff (rst)
        shutdown_o |=> shutdown_o);

    a_r5_hot_sets_hw: assert property (@(posedge clk) disable iff (rst)
        (temp_i >= thr_hot_i) |=> throt_hw_o);

    a_r6_hold_in_band: assert property (@(posedge clk) disable iff (rst)
        (throt_hw_o && ({1'b0, temp_i} + {1'b0, hyst_i} >= {1'b0, thr_hot_i})) |=> throt_hw_o);

    a_r7_sw_follows: assert property (@(posedge clk) disable iff (rst)
        sw_throttle_i |=> throt_sw_o);

    a_r9_duty_only_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (win_pos != '0) |-> $stable(act_duty));

    a_r2_stall_needs_duty: assert property (@(posedge clk) disable iff (rst)
        !clk_en_o |-> (act_duty != '0));
endmodule

bind thermal_throttle_unit thermal_throttle_unit_chk #(.TEMP_W(TEMP_W), .DUTY_W(DUTY_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .temp_i        (temp_i),
    .thr_hot_i     (thr_hot_i),
    .thr_crit_i    (thr_crit_i),
    .hyst_i        (hyst_i),
    .sw_throttle_i (sw_throttle_i),
    .clk_en_o      (clk_en_o),
    .throt_hw_o    (throt_hw_o),
    .throt_sw_o    (throt_sw_o),
    .shutdown_o    (shutdown_o),
    .win_pos       (win_pos),
    .act_duty      (act_duty)
);

// File: tb/thermal_throttle_unit_tb.sv
module thermal_throttle_unit_tb;
    localparam int TW = 8;
    localparam int DW = 4;
    localparam int WIN = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] temp = '0;
    logic [TW-1:0] hot = 8'd100;
    logic [TW-1:0] crit = 8'd200;
    logic [TW-1:0] hyst = 8'd10;
    logic [DW-1:0] duty = '0;
    logic          sw = 1'b0;
    logic          clk_en, thw, tsw, shut;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    thermal_throttle_unit u_dut (
        .clk(clk), .rst(rst), .temp_i(temp), .thr_hot_i(hot), .thr_crit_i(crit),
        .hyst_i(hyst), .duty_i(duty), .sw_throttle_i(sw),
        .clk_en_o(clk_en), .throt_hw_o(thw), .throt_sw_o(tsw), .shutdown_o(shut)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sw = 1'b0; temp = '0; duty = '0;
        step(3);
        rst = 1'b0;
    endtask

    task automatic align();
        @(negedge clk);
        while (cyc % WIN != 0) @(negedge clk);
    endtask

    // Sample one full window from position 0; count stalls and misplaced stalls.
    task automatic measure(input string req, input int exp_n);
        int stalls = 0;
        int misplaced = 0;
        align();
        for (int p = 0; p < WIN; p++) begin
            if (!clk_en) stalls++;
            if ((!clk_en) != (p < exp_n)) misplaced++;
            @(negedge clk);
        end
        chk({req, " stall count"}, stalls, exp_n);
        chk({req, " stall placement"}, misplaced, 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        step(1);
        chk("R10 clk_en", clk_en, 1);
        chk("R10 hw flag", thw, 0);
        chk("R10 sw flag", tsw, 0);
        chk("R10 shutdown", shut, 0);
    endtask

    task automatic t_full_run();
        int lows = 0;
        duty = 4'd5; temp = 8'd50;
        for (int i = 0; i < 2 * WIN; i++) begin
            @(negedge clk);
            if (!clk_en) lows++;
        end
        chk("R1 no stalls when idle", lows, 0);
    endtask

    task automatic t_sw_throttle();
        temp = 8'd20; duty = 4'd4; sw = 1'b1;
        step(1);
        chk("R7 sw flag", tsw, 1);
        chk("R8 hw flag stays low", thw, 0);
        step(WIN + 1);
        measure("R7 R2 sw duty 4", 4);
        duty = 4'd0;
        step(WIN + 1);
        measure("R2 duty 0", 0);
        duty = 4'd15;
        step(WIN + 1);
        measure("R2 duty 15", 15);
        sw = 1'b0;
        step(WIN + 1);
        measure("R1 after sw release", 0);
    endtask

    task automatic t_boundary();
        int stalls;
        sw = 1'b1; duty = 4'd4;
        step(WIN + 1);
        align();
        step(8);
        duty = 4'd12;
        stalls = 0;
        for (int p = 8; p < WIN; p++) begin
            if (!clk_en) stalls++;
            @(negedge clk);
        end
        chk("R9 mid-window duty change ignored", stalls, 0);
        // now at position 0 of the next window
        stalls = 0;
        for (int p = 0; p < 5; p++) begin
            if (!clk_en) stalls++;
            @(negedge clk);
        end
        sw = 1'b0;
        for (int p = 5; p < WIN; p++) begin
            if (!clk_en) stalls++;
            @(negedge clk);
        end
        chk("R9 new duty and mid-window release", stalls, 12);
        measure("R9 release at next window", 0);
    endtask

    task automatic t_hw_throttle();
        sw = 1'b0; hot = 8'd100; hyst = 8'd10; duty = 4'd6; crit = 8'd250;
        temp = 8'd99;
        step(1);
        chk("R5 below hot", thw, 0);
        temp = 8'd100;
        step(1);
        chk("R5 at hot", thw, 1);
        chk("R8 sw flag stays low", tsw, 0);
        step(WIN + 1);
        measure("R5 R2 hw duty 6", 6);
        sw = 1'b1;
        step(1);
        chk("R8 both flags hw", thw, 1);
        chk("R8 both flags sw", tsw, 1);
        sw = 1'b0;
        temp = 8'd91;
        step(1);
        chk("R6 hold at 91", thw, 1);
        temp = 8'd90;
        step(1);
        chk("R6 hold at 90", thw, 1);
        temp = 8'd89;
        step(1);
        chk("R6 release at 89", thw, 0);
        step(WIN + 1);
        measure("R6 no stall after release", 0);
        // overflow-safe margin: large hysteresis must not wrap the sum
        hyst = 8'd200; temp = 8'd100;
        step(1);
        temp = 8'd60;
        step(1);
        chk("R6 no wrap of margin sum", thw, 1);
        hyst = 8'd10; temp = 8'd0;
        step(1);
        chk("R6 release at 0", thw, 0);
    endtask

    task automatic t_shutdown();
        int drops = 0;
        crit = 8'd200; temp = 8'd199;
        step(1);
        chk("R3 below crit", shut, 0);
        temp = 8'd200;
        step(1);
        chk("R3 at crit", shut, 1);
        temp = 8'd0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!shut) drops++;
        end
        chk("R4 sticky", drops, 0);
        do_reset();
        step(1);
        chk("R4 cleared by reset", shut, 0);
    endtask

    initial begin
        t_reset_state();
        t_full_run();
        t_sw_throttle();
        t_boundary();
        t_hw_throttle();
        t_shutdown();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule